// File: doc/BRIEF.md
# Filtered GPIO Input Interrupt Detector

This block conditions the inputs of a bank of general-purpose pins and turns them into interrupts. Every pin passes through a two-flop synchronizer, an optional inversion and a glitch filter. The filtered value of each pin is available on a port and through a read register. For the low-numbered pins it can also drive an interrupt, either as a level or as a latched rising edge.

The filter does not use a private timer for each pin. One free-running counter is shared by the whole bank, and each pin picks one bit of that counter. The cycle on which the chosen bit turns from 0 to 1 is the pin's sample strobe. A pin's filtered state changes only after a programmed number of consecutive samples disagree with it. Software drives the block through a single-cycle write port and a combinational read port. Each pin has its own configuration word. A shared input-data word reads back the filtered values, and a write-one-to-clear word clears latched edge interrupts.

Top module: `gpio_filt_irq`

## Requirements
- R1: After reset every pin configuration word reads 0, the input-data word reads 0, and `irq_o` and `oe_o` are all 0.
- R2: A pin with sample select S (configuration bits [11:8]) samples its synchronized input once every 2^(S+1) clock cycles. These are the cycles on which bit S of a shared free-running counter goes from 0 to 1.
- R3: With count N (configuration bits [7:4]), the filtered value of a pin changes only after N+1 consecutive samples that disagree with it. A pulse that spans only N samples leaves the filtered value unchanged. N = 0 lets a single sample decide.
- R4: Configuration bit [1] inverts the sensed pin value before it reaches the filter and the interrupt logic.
- R5: A read of address 0x20 returns the filtered values of all pins, with bit i holding pin i and the unused upper bits set to 0.
- R6: In level mode (configuration bit [3] = 0), `irq_o[i]` equals the filtered value of pin i ANDed with its interrupt enable (configuration bit [2]).
- R7: In edge mode (configuration bit [3] = 1), a rising transition of the filtered value sets a latch while the enable is 1. The latch is held until it is cleared, and `irq_o[i]` shows the latch. A rise that occurs while the enable is 0 is not captured.
- R8: Writing address 0x21 with bit i set clears the edge latch of pin i. Bits written as 0 leave the other latches untouched.
- R9: Only pins 0 to 15 can interrupt. On pins 16 and above, the enable and edge-mode bits are stored as 0 and read back as 0. All other fields of those pins keep their written values.
- R10: A read of address i (i below the pin count) returns that pin's 12-bit configuration word, and `oe_o[i]` follows configuration bit [0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw pin levels, asynchronous to the clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address for reads and writes |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational in `addr_i` |
| filt_o | output | NUM_PINS | Filtered pin values |
| oe_o | output | NUM_PINS | Per-pin output enable from the configuration |
| irq_o | output | NUM_IRQ | Per-pin interrupt outputs |

## Verification
The hardest case to produce from the ports is the exact acceptance boundary of the filter. The strobe phase comes from a shared counter that the bench cannot see. Any window of k·2^(S+1) consecutive cycles contains exactly k strobes, whatever the phase. The bench therefore holds a pin for N·2^(S+1) cycles and expects no change, then holds it for (N+1)·2^(S+1) cycles and expects a change. It sweeps this over several pins, every select from 0 to 2 and every count from 0 to 3.

// File: rtl/gpio_filt_pkg.sv
package gpio_filt_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 12;
    localparam int SEL_W  = 4;
    localparam int RUN_W  = 4;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 6'h20;
    localparam logic [ADDR_W-1:0] ADDR_CLR  = 6'h21;

    // per-pin configuration word, bit 0 at the bottom
    typedef struct packed {
        logic [SEL_W-1:0] sel;        // [11:8] counter bit used as strobe
        logic [RUN_W-1:0] cnt;        // [7:4]  extra agreeing samples needed
        logic             edge_mode;  // [3]    0 level, 1 rising edge
        logic             irq_en;     // [2]
        logic             inv;        // [1]
        logic             oe;         // [0]
    } pin_cfg_t;

    typedef struct packed {
        logic             sync0;
        logic             sync1;
        logic             filt;
        logic [RUN_W-1:0] run;
        logic             edge_flag;
    } pin_state_t;

endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] tick_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // bit b has just risen when it is 1 and all bits below it are 0
    for (genvar b = 0; b < CNT_W; b++) begin : g_tick
        localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'((64'd1 << b) - 64'd1);
        assign tick_o[b] = cnt_q[b] & ~|(cnt_q & LOW_MASK);
    end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_filt_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_IRQ  = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output pin_cfg_t [NUM_PINS-1:0]      cfg_o,
    output logic [NUM_IRQ-1:0]           clr_o
);
    pin_cfg_t [NUM_PINS-1:0] cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];

    always_comb begin
        cfg_d = cfg_q;
        clr_o = '0;
        if (wr_en_i) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (addr_i == ADDR_W'(p)) begin
                    cfg_d[p] = pin_cfg_t'(wdata_i[CFG_W-1:0]);
                    if (p >= NUM_IRQ) begin
                        cfg_d[p].irq_en    = 1'b0;
                        cfg_d[p].edge_mode = 1'b0;
                    end
                end
            end
            if (addr_i == ADDR_CLR) clr_o = wdata_i[NUM_IRQ-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
    import gpio_filt_pkg::*;
#(
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     pin_i,
    input  logic     tick_i,
    input  pin_cfg_t cfg_i,
    input  logic     clr_i,
    output logic     filt_o,
    output logic     irq_o
);
    pin_state_t st_d, st_q;
    logic       smp;
    logic       unused_oe;

    assign unused_oe = cfg_i.oe;

    always_comb begin
        st_d       = st_q;
        st_d.sync0 = pin_i;
        st_d.sync1 = st_q.sync0;
        smp        = st_q.sync1 ^ cfg_i.inv;

        if (tick_i) begin
            if (smp == st_q.filt) begin
                st_d.run = '0;
            end else if (st_q.run >= cfg_i.cnt) begin
                st_d.filt = smp;
                st_d.run  = '0;
            end else begin
                st_d.run = st_q.run + RUN_W'(1);
            end
        end

        if (HAS_IRQ) begin
            if (clr_i) st_d.edge_flag = 1'b0;
            // a new rise wins over a clear in the same cycle
            if (cfg_i.irq_en && cfg_i.edge_mode && st_d.filt && !st_q.filt)
                st_d.edge_flag = 1'b1;
            irq_o = cfg_i.irq_en & (cfg_i.edge_mode ? st_q.edge_flag : st_q.filt);
        end else begin
            st_d.edge_flag = 1'b0;
            irq_o          = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign filt_o = st_q.filt;
endmodule

// File: rtl/gpio_filt_irq.sv
module gpio_filt_irq
    import gpio_filt_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_IRQ  = 16,
    parameter int CNT_W    = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_PINS-1:0] filt_o,
    output logic [NUM_PINS-1:0] oe_o,
    output logic [NUM_IRQ-1:0]  irq_o
);
    pin_cfg_t [NUM_PINS-1:0] cfg_all;
    logic [NUM_IRQ-1:0]      clr_vec;
    logic [CNT_W-1:0]        tick_all;

    gpio_tick_gen #(.CNT_W(CNT_W)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick_all)
    );

    gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) i_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .cfg_o   (cfg_all),
        .clr_o   (clr_vec)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign oe_o[p] = cfg_all[p].oe;
        if (p < NUM_IRQ) begin : g_irq
            gpio_pin_filter #(.HAS_IRQ(1'b1)) i_filt (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .pin_i  (pin_i[p]),
                .tick_i (tick_all[cfg_all[p].sel]),
                .cfg_i  (cfg_all[p]),
                .clr_i  (clr_vec[p]),
                .filt_o (filt_o[p]),
                .irq_o  (irq_o[p])
            );
        end else begin : g_noirq
            logic unused_irq;
            gpio_pin_filter #(.HAS_IRQ(1'b0)) i_filt (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .pin_i  (pin_i[p]),
                .tick_i (tick_all[cfg_all[p].sel]),
                .cfg_i  (cfg_all[p]),
                .clr_i  (1'b0),
                .filt_o (filt_o[p]),
                .irq_o  (unused_irq)
            );
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr_i == ADDR_W'(p)) rdata_o = DATA_W'(cfg_all[p]);
        end
        if (addr_i == ADDR_DATA) rdata_o = DATA_W'(filt_o);
    end
endmodule

// File: rtl/gpio_filt_irq_chk.sv
module gpio_filt_irq_chk
    import gpio_filt_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_IRQ  = 16,
    parameter int CNT_W    = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [DATA_W-1:0]       rdata_o,
    input  logic [NUM_PINS-1:0]     filt_o,
    input  logic [NUM_IRQ-1:0]      irq_o,
    input  pin_cfg_t [NUM_PINS-1:0] cfg_all,
    input  logic [CNT_W-1:0]        tick_all
);
    // R2
    filt_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(filt_o) |-> $past(|tick_all));

    // R7
    edge_needs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(irq_o[0]) && cfg_all[0].edge_mode && $stable(cfg_all[0])) |-> $rose(filt_o[0]));

    // R8
    clear_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_CLR && wdata_i[0] && cfg_all[0].edge_mode)
        |=> (!irq_o[0] || $rose(filt_o[0])));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_all[0].irq_en |-> !irq_o[0]);

    // R9
    high_pin_noirq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i >= ADDR_W'(NUM_IRQ) && addr_i < ADDR_W'(NUM_PINS)) |-> rdata_o[3:2] == 2'b00);
endmodule

bind gpio_filt_irq gpio_filt_irq_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ),
    .CNT_W    (CNT_W)
) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .filt_o   (filt_o),
    .irq_o    (irq_o),
    .cfg_all  (cfg_all),
    .tick_all (tick_all)
);

// File: tb/test_gpio_filt_irq.sv
module test_gpio_filt_irq;
    localparam int NP = 20;
    localparam int NI = 16;
    localparam logic [5:0] A_DATA = 6'h20;
    localparam logic [5:0] A_CLR  = 6'h21;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins;
    logic          wr_en;
    logic [5:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NP-1:0] filt;
    logic [NP-1:0] oe;
    logic [NI-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_filt_irq #(.NUM_PINS(NP), .NUM_IRQ(NI), .CNT_W(16)) i_gpio_filt_irq (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .pin_i   (pins),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .filt_o  (filt),
        .oe_o    (oe),
        .irq_o   (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // called at a negedge: holds pin p at v for exactly n cycles, watching filt
    task automatic hold(input int p, input logic v, input int n, inout logic seen);
        pins[p] = v;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (filt[p]) seen = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        seen;
        logic [NP-1:0] pat;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pins = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'd3, r);   chk("R1 config word", r, 32'h0);
        rd(A_DATA, r); chk("R1 data word", r, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 oe", 32'(oe), 32'h0);

        // R5 data word under several patterns (reset config: fastest filter)
        for (int i = 0; i < NP + 3; i++) begin
            if (i < NP)       pat = NP'(1) << i;
            else if (i == NP) pat = '1;
            else if (i == NP + 1) pat = NP'(20'hA5A5A);
            else pat = NP'(20'h5A5A5);
            pins = pat;
            settle();
            rd(A_DATA, r);
            chk("R5 data word pattern", r, 32'(pat));
        end
        pins = '0;
        settle();

        // R10 readback and output enable
        wr(6'd7, 32'h5A1);
        rd(6'd7, r); chk("R10 config readback", r, 32'h5A1);
        chk("R10 oe follows bit0", 32'(oe), 32'h80);
        wr(6'd7, 32'h0);

        // R2 / R3 sweep of sample rate and count boundary
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 0 : (k == 1) ? 5 : 17;
            for (int s = 0; s < 3; s++) begin
                for (int n = 0; n < 4; n++) begin
                    int per;
                    per = 2 << s;
                    wr(6'(p), {20'h0, 4'(s), 4'(n), 4'h0});
                    seen = 1'b0;
                    hold(p, 1'b0, per + 8, seen);
                    if (n > 0) begin
                        seen = 1'b0;
                        hold(p, 1'b1, n * per, seen);
                        hold(p, 1'b0, (n + 2) * per + 8, seen);
                        chk("R3 pulse of N samples rejected", 32'(seen), 32'h0);
                    end
                    seen = 1'b0;
                    hold(p, 1'b1, (n + 1) * per, seen);
                    hold(p, 1'b0, (n + 2) * per + 8, seen);
                    chk("R2 R3 pulse of N+1 samples accepted", 32'(seen), 32'h1);
                    chk("R3 filter returns low", 32'(filt[p]), 32'h0);
                end
            end
            wr(6'(p), 32'h0);
        end

        // R4 inversion
        wr(6'd2, 32'h002);
        pins[2] = 1'b0; settle();
        rd(A_DATA, r); chk("R4 inverted low reads high", 32'(r[2]), 32'h1);
        pins[2] = 1'b1; settle();
        chk("R4 inverted high filters low", 32'(filt[2]), 32'h0);
        wr(6'd2, 32'h0); pins[2] = 1'b0; settle();

        // R6 level mode
        wr(6'd1, 32'h004);
        pins[1] = 1'b1; settle();
        chk("R6 level irq high", 32'(irq[1]), 32'h1);
        pins[1] = 1'b0; settle();
        chk("R6 level irq follows low", 32'(irq[1]), 32'h0);
        wr(6'd1, 32'h000);
        pins[1] = 1'b1; settle();
        chk("R6 disabled level irq quiet", 32'(irq[1]), 32'h0);
        chk("R6 filter still high", 32'(filt[1]), 32'h1);
        pins[1] = 1'b0; settle();

        // R7 / R8 edge mode and clearing
        wr(6'd4, 32'h00C);
        pins[4] = 1'b1; settle();
        chk("R7 edge irq set", 32'(irq[4]), 32'h1);
        pins[4] = 1'b0; settle();
        chk("R7 edge irq held after fall", 32'(irq[4]), 32'h1);
        wr(A_CLR, 32'h20);
        chk("R8 other bit leaves latch", 32'(irq[4]), 32'h1);
        wr(A_CLR, 32'h10);
        chk("R8 clear drops latch", 32'(irq[4]), 32'h0);
        pins[4] = 1'b1; settle();
        chk("R7 second rise sets latch", 32'(irq[4]), 32'h1);
        wr(A_CLR, 32'h10); settle();
        chk("R8 clear while high stays clear", 32'(irq[4]), 32'h0);
        pins[4] = 1'b0; settle();
        wr(6'd4, 32'h008);
        pins[4] = 1'b1; settle();
        wr(6'd4, 32'h00C);
        chk("R7 rise while disabled not captured", 32'(irq[4]), 32'h0);
        pins[4] = 1'b0; settle();

        // R9 interrupt fields only on low pins
        wr(6'd18, 32'hFFF);
        rd(6'd18, r); chk("R9 high pin irq bits read zero", r, 32'hFF3);
        chk("R10 oe on high pin", 32'(oe[18]), 32'h1);
        wr(6'd18, 32'h0);
        wr(6'd15, 32'h00C);
        rd(6'd15, r); chk("R9 pin 15 keeps irq bits", r, 32'h00C);
        pins[15] = 1'b1; settle();
        chk("R9 pin 15 edge irq", 32'(irq[15]), 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule